// File: doc/BRIEF.md
# Memory-Module Description Image Builder

This block turns two parameters, a memory family code and a capacity in megabytes, into the 256-byte description image that a memory module carries in its serial parameter store. A single `start` pulse samples both inputs. The block checks them, rounds the capacity down to a power of two, and falls back to an older family when the capacity is too small for the one requested. It then splits the capacity into banks through a short iterative loop and folds the per-bank density into one byte using a family-specific layout.

Once the geometry is settled, the block streams the image out through a plain write port, one byte per clock, from address 0 to address 255. It adds up the checksum while the leading bytes go out. A one-cycle `done` pulse closes every request. At that pulse, `error` and `warning` show the outcome, and they hold that value until the next accepted `start`. The intended use is to fill a small RAM or register file that a serial-bus target later serves to a host.

Top module: `spd_image_gen`

## Requirements
- R1: The accepted family codes are 4 (single rate), 7 (double rate) and 8 (second-generation double rate). Any other code, or a capacity below 4 MB, raises `error` and produces no write. `done` pulses in the cycle right after the start edge.
- R2: The capacity is truncated to its highest set bit, giving a log2 size. If any lower bit was set, `warning` is raised.
- R3: Each family has a log2 range: code 4 covers 2 to 9, code 7 covers 5 to 12, and code 8 covers 7 to 14. If the log2 size is below the minimum for the requested family, the family becomes code 7 when the truncated size is 32 MB or more, and code 4 otherwise. `warning` is raised in both cases.
- R4: The bank count starts at 1. While the log2 size exceeds the family maximum and there are fewer than 8 banks, the loop takes one cycle per step, lowering the log2 size by one and adding one bank. If banks times 2^log2 ends up smaller than the truncated size, `warning` is raised.
- R5: If the loop ends with a single bank and a log2 size above the family minimum, the capacity is split once more, giving 2 banks and a log2 size one lower.
- R6: Byte 31 is built from d = 1 << (log2 − 2). For code 8 it is {d[7:5], d[12:8]}, for code 7 it is {d[7:3], d[10:8]}, and for code 4 it is d[7:0].
- R7: Byte 2 holds the final family code. Byte 5 holds banks−1 for code 8 and banks for the other families. Bytes 15 and 19 are 0 for code 8 and 1 for the other families.
- R8: The constant bytes are: 0=128, 1=8, 3=13, 4=10, 6=64, 8=4, 9=0x25, 10=1, 12=0x82, 13=8, 16=12, 17=4, 18=12, 20=2, 23=0x12, 27=20, 28=15, 29=20, 30=45, 32=20, 33=8, 34=20, 35=8. Every byte not named in R6 to R9 is 0.
- R9: Byte 63 is the sum, modulo 256, of bytes 0 to 62.
- R10: The image is written on 256 consecutive cycles at addresses 0, 1, ..., 255, with exactly one `wr_en` cycle per byte. Byte 0 appears i+3 cycles after the start edge, where i is the number of loop steps. `done` pulses for one cycle in the cycle after byte 255.
- R11: A `start` that arrives while a request is in progress has no effect on the image, the timing or the flags.
- R12: After reset, `wr_en`, `done`, `error` and `warning` are 0. `error` and `warning` keep the outcome of a request until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; inputs sampled when idle |
| type_code | input | 8 | Requested memory family code |
| size_mb | input | SIZE_W | Capacity in megabytes |
| wr_addr | output | 8 | Image byte address |
| wr_data | output | 8 | Image byte value |
| wr_en | output | 1 | Write strobe, one per byte |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request rejected, no image |
| warning | output | 1 | Request adjusted (truncation, fallback, coverage) |

## Verification
For a rejected request, `done` and `error` are due in the cycle after the start edge. For an accepted request, the bench's own model finds the number of loop steps i. It then expects byte 0 on cycle i+3 and `done` on cycle exactly i+259, both counted from the start edge. The bench numbers every falling edge after the start edge, records each write, and checks `done`, the flags and the complete image at the cycle index the model gives, so a missing or extra pipeline stage shows up as a latency failure and not as a timeout. A second start pulse in the middle of a stream must leave the count, the order and the contents of the writes unchanged.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int LG_W      = 5;
    localparam int BANK_W    = 4;
    localparam int MAX_BANKS = 8;
    localparam int IMG_BYTES = 256;
    localparam int ADDR_W    = $clog2(IMG_BYTES);
    localparam int CSUM_ADDR = 63;
    localparam int DENS_ADDR = 31;

    typedef enum logic [7:0] {
        MT_SDR  = 8'd4,
        MT_DDR  = 8'd7,
        MT_DDR2 = 8'd8
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_EMIT,
        ST_FIN
    } gen_state_e;

    typedef struct packed {
        mem_kind_e        kind;
        logic [LG_W-1:0]  lg;
        logic [LG_W-1:0]  lg_min;
        logic [LG_W-1:0]  lg_max;
    } geom_t;

    function automatic logic [LG_W-1:0] kind_lg_min(mem_kind_e k);
        case (k)
            MT_DDR2: return LG_W'(7);
            MT_DDR:  return LG_W'(5);
            default: return LG_W'(2);
        endcase
    endfunction

    function automatic logic [LG_W-1:0] kind_lg_max(mem_kind_e k);
        case (k)
            MT_DDR2: return LG_W'(14);
            MT_DDR:  return LG_W'(12);
            default: return LG_W'(9);
        endcase
    endfunction

    function automatic logic [7:0] fold_density(mem_kind_e k, logic [LG_W-1:0] lg);
        logic [31:0] d;
        d = 32'd1 << (lg - LG_W'(2));
        case (k)
            MT_DDR2: return {d[7:5], d[12:8]};
            MT_DDR:  return {d[7:3], d[10:8]};
            default: return d[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spd_size_norm.sv
module spd_size_norm
    import spd_pkg::*;
#(
    parameter int SIZE_W = 24
) (
    input  logic [7:0]        type_code,
    input  logic [SIZE_W-1:0] size_mb,
    output logic              bad,
    output logic              adjusted,
    output geom_t             geom
);
    logic [LG_W-1:0]   lg;
    logic [SIZE_W-1:0] pow;
    logic              known;
    mem_kind_e         req_kind;
    mem_kind_e         eff_kind;
    logic              fell_back;

    always_comb begin
        lg = '0;
        for (int b = 0; b < SIZE_W; b++) begin
            if (size_mb[b]) lg = LG_W'(b);
        end
    end

    assign pow = SIZE_W'(1) << lg;

    always_comb begin
        known    = 1'b1;
        req_kind = MT_SDR;
        case (type_code)
            8'd4:    req_kind = MT_SDR;
            8'd7:    req_kind = MT_DDR;
            8'd8:    req_kind = MT_DDR2;
            default: known = 1'b0;
        endcase
    end

    always_comb begin
        fell_back = lg < kind_lg_min(req_kind);
        eff_kind  = req_kind;
        if (fell_back) eff_kind = (lg >= LG_W'(5)) ? MT_DDR : MT_SDR;
    end

    assign bad      = !known || (size_mb < SIZE_W'(4));
    assign adjusted = (size_mb != pow) || fell_back;

    assign geom.kind   = eff_kind;
    assign geom.lg     = lg;
    assign geom.lg_min = kind_lg_min(eff_kind);
    assign geom.lg_max = kind_lg_max(eff_kind);

endmodule

// File: rtl/spd_bank_split.sv
module spd_bank_split
    import spd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  geom_t             geom_in,
    output logic              fin,
    output logic [LG_W-1:0]   lg_out,
    output logic [BANK_W-1:0] banks_out,
    output logic              short_cover
);
    logic              run_q;
    logic [LG_W-1:0]   lg_q;
    logic [LG_W-1:0]   orig_q;
    logic [LG_W-1:0]   min_q;
    logic [LG_W-1:0]   max_q;
    logic [BANK_W-1:0] banks_q;
    logic              fin_q;
    logic              short_q;
    logic [39:0]       span_orig;
    logic [39:0]       span_now;
    logic              step;

    assign span_orig = 40'd1 << orig_q;
    assign span_now  = 40'(banks_q) << lg_q;
    assign step      = (lg_q > max_q) && (banks_q < BANK_W'(MAX_BANKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            lg_q    <= '0;
            orig_q  <= '0;
            min_q   <= '0;
            max_q   <= '0;
            banks_q <= BANK_W'(1);
            fin_q   <= 1'b0;
            short_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                run_q   <= 1'b1;
                lg_q    <= geom_in.lg;
                orig_q  <= geom_in.lg;
                min_q   <= geom_in.lg_min;
                max_q   <= geom_in.lg_max;
                banks_q <= BANK_W'(1);
                short_q <= 1'b0;
            end else if (run_q) begin
                if (step) begin
                    lg_q    <= lg_q - LG_W'(1);
                    banks_q <= banks_q + BANK_W'(1);
                end else begin
                    run_q   <= 1'b0;
                    fin_q   <= 1'b1;
                    short_q <= span_orig > span_now;
                    if (banks_q == BANK_W'(1) && lg_q > min_q) begin
                        lg_q    <= lg_q - LG_W'(1);
                        banks_q <= BANK_W'(2);
                    end
                end
            end
        end
    end

    assign fin         = fin_q;
    assign lg_out      = lg_q;
    assign banks_out   = banks_q;
    assign short_cover = short_q;

    AST_BANKS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (banks_q >= BANK_W'(1)) && (banks_q <= BANK_W'(MAX_BANKS))); // R4
    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q); // R4
    AST_FORCED_PAIR: assert property (@(posedge clk) disable iff (rst)
        run_q && !load && !step && banks_q == BANK_W'(1) && lg_q > min_q
        |=> banks_q == BANK_W'(2)); // R5

endmodule

// File: rtl/spd_byte_map.sv
module spd_byte_map
    import spd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  mem_kind_e         kind,
    input  logic [LG_W-1:0]   lg,
    input  logic [BANK_W-1:0] banks,
    output logic [7:0]        value
);
    logic       gen2;
    logic [7:0] bank_byte;
    logic [7:0] flag_byte;

    assign gen2      = (kind == MT_DDR2);
    assign bank_byte = gen2 ? 8'(banks - BANK_W'(1)) : 8'(banks);
    assign flag_byte = gen2 ? 8'd0 : 8'd1;

    always_comb begin
        case (addr)
            8'd0:      value = 8'd128;
            8'd1:      value = 8'd8;
            8'd2:      value = kind;
            8'd3:      value = 8'd13;
            8'd4:      value = 8'd10;
            8'd5:      value = bank_byte;
            8'd6:      value = 8'd64;
            8'd8:      value = 8'd4;
            8'd9:      value = 8'h25;
            8'd10:     value = 8'd1;
            8'd12:     value = 8'h82;
            8'd13:     value = 8'd8;
            8'd15:     value = flag_byte;
            8'd16:     value = 8'd12;
            8'd17:     value = 8'd4;
            8'd18:     value = 8'd12;
            8'd19:     value = flag_byte;
            8'd20:     value = 8'd2;
            8'd23:     value = 8'h12;
            8'd27:     value = 8'd20;
            8'd28:     value = 8'd15;
            8'd29:     value = 8'd20;
            8'd30:     value = 8'd45;
            DENS_ADDR: value = fold_density(kind, lg);
            8'd32:     value = 8'd20;
            8'd33:     value = 8'd8;
            8'd34:     value = 8'd20;
            8'd35:     value = 8'd8;
            default:   value = 8'd0;
        endcase
    end

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
    import spd_pkg::*;
#(
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        type_code,
    input  logic [SIZE_W-1:0] size_mb,
    output logic [7:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_en,
    output logic              done,
    output logic              error,
    output logic              warning
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_BYTES - 1);

    gen_state_e        state_q;
    logic [ADDR_W-1:0] cnt_q;
    logic [7:0]        csum_q;
    mem_kind_e         kind_q;
    logic              err_q;
    logic              warn_q;
    logic              done_q;
    logic              we_q;
    logic [7:0]        addr_q;
    logic [7:0]        data_q;

    logic              n_bad;
    logic              n_adj;
    geom_t             n_geom;
    logic              accept;
    logic              s_fin;
    logic [LG_W-1:0]   s_lg;
    logic [BANK_W-1:0] s_banks;
    logic              s_short;
    logic [7:0]        byte_now;

    spd_size_norm #(.SIZE_W(SIZE_W)) u_norm (
        .type_code (type_code),
        .size_mb   (size_mb),
        .bad       (n_bad),
        .adjusted  (n_adj),
        .geom      (n_geom)
    );

    assign accept = (state_q == ST_IDLE) && start;

    spd_bank_split u_split (
        .clk         (clk),
        .rst         (rst),
        .load        (accept && !n_bad),
        .geom_in     (n_geom),
        .fin         (s_fin),
        .lg_out      (s_lg),
        .banks_out   (s_banks),
        .short_cover (s_short)
    );

    spd_byte_map u_map (
        .addr  (cnt_q),
        .kind  (kind_q),
        .lg    (s_lg),
        .banks (s_banks),
        .value (byte_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            csum_q  <= '0;
            kind_q  <= MT_SDR;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
            done_q  <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            done_q <= 1'b0;
            we_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q  <= n_bad;
                        warn_q <= n_bad ? 1'b0 : n_adj;
                        kind_q <= n_geom.kind;
                        if (n_bad) done_q  <= 1'b1;
                        else       state_q <= ST_SPLIT;
                    end
                end
                ST_SPLIT: begin
                    if (s_fin) begin
                        warn_q  <= warn_q | s_short;
                        cnt_q   <= '0;
                        csum_q  <= '0;
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    we_q   <= 1'b1;
                    addr_q <= 8'(cnt_q);
                    data_q <= (cnt_q == ADDR_W'(CSUM_ADDR)) ? csum_q : byte_now;
                    if (cnt_q < ADDR_W'(CSUM_ADDR)) csum_q <= csum_q + byte_now;
                    if (cnt_q == LAST_ADDR) state_q <= ST_FIN;
                    else                    cnt_q   <= cnt_q + ADDR_W'(1);
                end
                default: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign wr_en   = we_q;
    assign done    = done_q;
    assign error   = err_q;
    assign warning = warn_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 8'd1); // R10
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (rst)
        wr_en && !$past(wr_en) |-> wr_addr == 8'd0); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        error |-> !wr_en); // R1
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done && !error |-> $past(wr_en) && $past(wr_addr) == 8'd255); // R10

endmodule

// File: tb/spd_image_gen_bench.sv
module spd_image_gen_bench;
    localparam int SIZE_W = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [7:0]        type_code = 8'd0;
    logic [SIZE_W-1:0] size_mb = '0;
    logic [7:0]        wr_addr;
    logic [7:0]        wr_data;
    logic              wr_en;
    logic              done;
    logic              error;
    logic              warning;

    int total = 0;
    int bad   = 0;

    int exp_err, exp_warn, exp_kind, exp_lg, exp_banks, exp_steps;
    logic [7:0] exp_img [256];
    logic [7:0] got_img [256];

    always #4 clk = ~clk;

    spd_image_gen #(.SIZE_W(SIZE_W)) u_spd_image_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .type_code (type_code),
        .size_mb   (size_mb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .done      (done),
        .error     (error),
        .warning   (warning)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements
    task automatic model(input int ty, input int sz);
        int lg, kind, lmin, lmax, banks, d, dens, sum;
        exp_err = 0; exp_warn = 0; exp_steps = 0;
        for (int a = 0; a < 256; a++) exp_img[a] = 8'd0;
        if (!(ty == 4 || ty == 7 || ty == 8) || sz < 4) begin
            exp_err = 1;
            return;
        end
        lg = 0;
        for (int b = 0; b < SIZE_W; b++) if (sz >= (1 << b)) lg = b;
        if (sz != (1 << lg)) exp_warn = 1;                       // R2
        kind = ty;
        lmin = (kind == 8) ? 7 : (kind == 7) ? 5 : 2;
        if (lg < lmin) begin                                     // R3
            exp_warn = 1;
            kind = ((1 << lg) >= 32) ? 7 : 4;
        end
        lmin = (kind == 8) ? 7 : (kind == 7) ? 5 : 2;
        lmax = (kind == 8) ? 14 : (kind == 7) ? 12 : 9;
        banks = 1;
        while (lg > lmax && banks < 8) begin                     // R4
            lg--; banks++; exp_steps++;
        end
        if ((longint'(1) << (lg + exp_steps)) > (longint'(banks) << lg)) exp_warn = 1;
        if (banks == 1 && lg > lmin) begin lg--; banks = 2; end  // R5
        exp_kind = kind; exp_lg = lg; exp_banks = banks;
        d = 1 << (lg - 2);                                       // R6
        if (kind == 8)      dens = (d & 'he0) | ((d >> 8) & 'h1f);
        else if (kind == 7) dens = (d & 'hf8) | ((d >> 8) & 'h07);
        else                dens = d & 'hff;
        exp_img[0] = 128;  exp_img[1] = 8;    exp_img[2] = 8'(kind);
        exp_img[3] = 13;   exp_img[4] = 10;
        exp_img[5] = 8'((kind == 8) ? banks - 1 : banks);
        exp_img[6] = 64;   exp_img[8] = 4;    exp_img[9] = 8'h25;
        exp_img[10] = 1;   exp_img[12] = 8'h82; exp_img[13] = 8;
        exp_img[15] = (kind == 8) ? 8'd0 : 8'd1;
        exp_img[16] = 12;  exp_img[17] = 4;   exp_img[18] = 12;
        exp_img[19] = (kind == 8) ? 8'd0 : 8'd1;
        exp_img[20] = 2;   exp_img[23] = 8'h12;
        exp_img[27] = 20;  exp_img[28] = 15;  exp_img[29] = 20;
        exp_img[30] = 45;  exp_img[31] = 8'(dens);
        exp_img[32] = 20;  exp_img[33] = 8;   exp_img[34] = 20; exp_img[35] = 8;
        sum = 0;
        for (int a = 0; a < 63; a++) sum += exp_img[a];          // R9
        exp_img[63] = 8'(sum);
    endtask

    // One request; poke issues an extra start in the middle of the stream
    task automatic run_case(input string name, input int ty, input int sz, input bit poke);
        int cyc, writes, order_bad, mism, done_cyc;
        model(ty, sz);
        for (int a = 0; a < 256; a++) got_img[a] = 8'hxx;
        @(negedge clk);
        type_code = 8'(ty); size_mb = SIZE_W'(sz); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        if (exp_err) begin
            chk("R1", {name, " done at once"}, done, 1);
            chk("R1", {name, " error"}, error, 1);
            writes = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (wr_en) writes++;
            end
            chk("R1", {name, " no writes"}, writes, 0);
            chk("R12", {name, " error held"}, error, 1);
            return;
        end
        writes = 0; order_bad = 0; done_cyc = -1;
        while (cyc < 400 && done_cyc < 0) begin
            if (wr_en) begin
                if (wr_addr != 8'(writes)) order_bad++;
                got_img[wr_addr] = wr_data;
                writes++;
            end
            if (done) done_cyc = cyc;
            if (poke && cyc == 60) begin
                type_code = 8'd8; size_mb = SIZE_W'(4096); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R10", {name, " done latency"}, done_cyc, exp_steps + 259);
        chk("R10", {name, " write count"}, writes, 256);
        chk("R10", {name, " address order"}, order_bad, 0);
        chk("R1",  {name, " no error"}, error, 0);
        chk("R12", {name, " warning"}, warning, exp_warn);
        chk("R7",  {name, " byte2 kind"}, got_img[2], exp_img[2]);
        chk("R7",  {name, " byte5 banks"}, got_img[5], exp_img[5]);
        chk("R6",  {name, " byte31 density"}, got_img[31], exp_img[31]);
        chk("R9",  {name, " byte63 checksum"}, got_img[63], exp_img[63]);
        mism = 0;
        for (int a = 0; a < 256; a++) if (got_img[a] !== exp_img[a]) mism++;
        chk("R8", {name, " whole image"}, mism, 0);
        @(negedge clk);
        chk("R10", {name, " done one cycle"}, done, 0);
        chk("R12", {name, " warning held"}, warning, exp_warn);
        if (poke) chk("R11", {name, " stays idle"}, wr_en, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R12", "reset wr_en", wr_en, 0);
        chk("R12", "reset done", done, 0);
        chk("R12", "reset error", error, 0);
        chk("R12", "reset warning", warning, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        run_case("R5 single-rate 128MB", 4, 128, 1'b0);
        run_case("R5 double-rate 256MB", 7, 256, 1'b0);
        run_case("R6 gen2 4096MB", 8, 4096, 1'b0);
        run_case("R2 single-rate 100MB", 4, 100, 1'b0);
        run_case("R3 gen2 64MB to code7", 8, 64, 1'b0);
        run_case("R3 gen2 16MB to code4", 8, 16, 1'b0);
        run_case("R4 single-rate 1024MB", 4, 1024, 1'b0);
        run_case("R4 single-rate 4096MB", 4, 4096, 1'b0);
        run_case("R4 double-rate 131072MB", 7, 131072, 1'b0);
        run_case("R4 single-rate cap 8 banks", 4, 1 << 20, 1'b0);
        run_case("R5 minimum 4MB", 4, 4, 1'b0);
        run_case("R1 size 3MB", 4, 3, 1'b0);
        run_case("R1 code 5", 5, 256, 1'b0);
        run_case("R12 clears after error", 7, 512, 1'b0);
        run_case("R11 start while busy", 4, 256, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule